// File: doc/BRIEF.md
# Chip-Select Bank Address Decoder

This block turns a system-bus address into one of eight active-low chip-selects for an external memory bus. Software sets up one 32-bit window register per bank through a small register port. Each register holds a base address aligned to 128 KiB, an inverted don't-care mask and an enable bit. Every address presented with a valid strobe is compared against all enabled windows at once. One cycle later, at most one chip-select is driven low, or a miss flag is raised.

A boot-swap strap is captured while reset is held. When it is set, the first two chip-select pins change places, so the register of bank 0 steers pin 1 and the register of bank 1 steers pin 0. The block also models a quirk of the bus. While the register of bank 0 or bank 1 reads zero, every access goes to bank 0's chip-select and no other bank can be reached. Software parks an unused bank 0 or bank 1 by writing all ones, which leaves it matching only the topmost 128 KiB.

Top module: `cs_bank_decoder`

## Requirements
- R1: Bank register i sits at register offset 0x100 + 0x10*i for i = 0..7, and a read returns the last value written to it. Reads of any other offset return zero, and writes to other offsets change no register.
- R2: After reset every bank register reads zero, except bit 0 of bank 0, which reads the inverse of the strap, and bit 0 of bank 1, which reads the strap.
- R3: A bank matches when its bit 0 (enable) is set and, for every address bit k in 31..17 whose care bit (register bit k-16) is 1, address bit k equals register bit k. A bank whose enable is clear never matches.
- R4: When several enabled banks match, the lowest-numbered bank wins, so at most one chip-select is low.
- R5: When no bank matches, the miss output is 1 and all chip-selects are high.
- R6: While the register of bank 0 or of bank 1 is zero, every access selects bank 0, whatever the other registers hold.
- R7: With the strap set at reset, chip-select pins 0 and 1 carry banks 1 and 0 respectively. All other pins are unchanged.
- R8: Chip-select and miss outputs are registered. They reflect an address sampled with the valid strobe one clock edge earlier. After an edge with no strobe, they are idle (all chip-selects high, miss 0).
- R9: A register write is seen by the decode of an access strobed on the next clock edge, but not by one strobed on the same edge.
- R10: A bank 0 or bank 1 register of all ones matches only addresses 0xFFFE0000 to 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the strap is captured while low |
| boot_swap_i | input | 1 | Boot-swap strap |
| reg_valid_i | input | 1 | Register access valid |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational, zero when not a read |
| bus_valid_i | input | 1 | Bus address strobe |
| bus_addr_i | input | 32 | Bus address |
| cs_n_o | output | 8 | Active-low chip-selects, registered |
| miss_o | output | 1 | No bank matched, registered |

## Verification
The properties assume that the strap does not change while reset is being released. They also assume that the bus address and the register port are sampled only at rising edges, with the strobes driven as single-cycle pulses. The stimulus drives every input on the falling edge and changes the strap only while reset is held low. Register reads are made with the write strobe low, so the read-data checks only ever see read cycles.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;
   // Default geometry of the decoder
   localparam int unsigned DEF_BANKS    = 8;
   localparam int unsigned DEF_ADDR_W   = 32;
   localparam int unsigned DEF_GRAN_LG2 = 17;
   localparam int unsigned DEF_REG_AW   = 12;
   localparam int unsigned DEF_BASE_OFF = 'h100;
   localparam int unsigned DEF_STRIDE   = 'h10;

   // Outcome of one decode, used for readability in the selector
   typedef enum logic [1:0] {
      DEC_MISS    = 2'd0,
      DEC_WINDOW  = 2'd1,
      DEC_CAPTURE = 2'd2
   } dec_kind_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/cs_dec_regfile.sv
module cs_dec_regfile
   import cs_dec_pkg::*;
#(
   parameter int unsigned NUM_BANKS = DEF_BANKS,
   parameter int unsigned DATA_W    = DEF_ADDR_W,
   parameter int unsigned REG_AW    = DEF_REG_AW,
   parameter int unsigned BASE_OFF  = DEF_BASE_OFF,
   parameter int unsigned STRIDE    = DEF_STRIDE
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           boot_swap_i,
   input  logic                           reg_valid_i,
   input  logic                           reg_write_i,
   input  logic [REG_AW-1:0]              reg_addr_i,
   input  logic [DATA_W-1:0]              reg_wdata_i,
   output logic [DATA_W-1:0]              reg_rdata_o,
   output logic [NUM_BANKS-1:0][DATA_W-1:0] bank_regs_o,
   output logic                           swap_o
);
   localparam int unsigned STRIDE_LG2 = $clog2(STRIDE);
   localparam int unsigned IDX_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam logic [REG_AW-1:0] BASE_A = REG_AW'(BASE_OFF);
   localparam logic [REG_AW-1:0] SPAN_A = REG_AW'(NUM_BANKS * STRIDE);

   logic [DATA_W-1:0] regs_q [NUM_BANKS];
   logic [REG_AW-1:0] off;
   logic              in_range;
   logic [IDX_W-1:0]  idx;
   logic              wr_en;
   logic              swap_q;

   // Offset decode: inside the bank window and on a stride boundary
   assign off      = reg_addr_i - BASE_A;
   assign in_range = (reg_addr_i >= BASE_A) && (off < SPAN_A)
                     && (off[STRIDE_LG2-1:0] == '0);
   assign idx      = off[STRIDE_LG2 +: IDX_W];
   assign wr_en    = reg_valid_i && reg_write_i && in_range;

   // Strap is followed while reset is held and frozen afterwards
   always_ff @(posedge clk) begin
      if (!rst_n) swap_q <= boot_swap_i;
   end
   assign swap_o = swap_q;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [DATA_W-1:0] rst_val;
      if (b == 0) begin : g_boot0
         assign rst_val = {{(DATA_W-1){1'b0}}, ~boot_swap_i};
      end else if (b == 1) begin : g_boot1
         assign rst_val = {{(DATA_W-1){1'b0}}, boot_swap_i};
      end else begin : g_plain
         assign rst_val = '0;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            regs_q[b] <= rst_val;
         end else if (wr_en && (idx == IDX_W'(b))) begin
            regs_q[b] <= reg_wdata_i;
         end
      end

      assign bank_regs_o[b] = regs_q[b];
   end

   always_comb begin
      reg_rdata_o = '0;
      if (reg_valid_i && !reg_write_i && in_range) begin
         reg_rdata_o = regs_q[idx];
      end
   end
endmodule

// File: rtl/cs_dec_match.sv
module cs_dec_match
   import cs_dec_pkg::*;
#(
   parameter int unsigned NUM_BANKS = DEF_BANKS,
   parameter int unsigned ADDR_W    = DEF_ADDR_W,
   parameter int unsigned GRAN_LG2  = DEF_GRAN_LG2
) (
   input  logic [NUM_BANKS-1:0][ADDR_W-1:0] bank_regs_i,
   input  logic [ADDR_W-1:0]                addr_i,
   output logic [NUM_BANKS-1:0]             hit_o,
   output logic                             capture_o
);
   localparam int unsigned TAG_W = ADDR_W - GRAN_LG2;

   logic [TAG_W-1:0] addr_tag;
   assign addr_tag = addr_i[ADDR_W-1:GRAN_LG2];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
      logic [TAG_W-1:0] base_tag;
      logic [TAG_W-1:0] care;
      logic             en;
      assign base_tag = bank_regs_i[b][ADDR_W-1:GRAN_LG2];
      assign care     = bank_regs_i[b][TAG_W:1];
      assign en       = bank_regs_i[b][0];
      assign hit_o[b] = en && (((addr_tag ^ base_tag) & care) == '0);

      // Bits between the mask field and the base field carry no meaning
      if (GRAN_LG2 > TAG_W + 1) begin : g_gap
         logic unused_gap;
         assign unused_gap = ^bank_regs_i[b][GRAN_LG2-1:TAG_W+1];
      end
   end

   logic unused_addr_low;
   assign unused_addr_low = ^addr_i[GRAN_LG2-1:0];

   // Zero in either of the two boot registers swallows every access
   assign capture_o = (bank_regs_i[0] == '0) || (bank_regs_i[1] == '0);
endmodule

// File: rtl/cs_dec_select.sv
module cs_dec_select
   import cs_dec_pkg::*;
#(
   parameter int unsigned NUM_BANKS = DEF_BANKS
) (
   input  logic [NUM_BANKS-1:0] hit_i,
   input  logic                 capture_i,
   input  logic                 swap_i,
   output logic [NUM_BANKS-1:0] sel_o,
   output logic                 miss_o
);
   logic [NUM_BANKS-1:0] logical;
   dec_kind_e            kind;

   always_comb begin
      logical = '0;
      kind    = DEC_MISS;
      if (capture_i) begin
         logical[0] = 1'b1;
         kind       = DEC_CAPTURE;
      end else begin
         for (int i = 0; i < NUM_BANKS; i++) begin
            if (hit_i[i] && (kind == DEC_MISS)) begin
               logical[i] = 1'b1;
               kind       = DEC_WINDOW;
            end
         end
      end
   end

   assign miss_o = (kind == DEC_MISS);

   // Logical bank to pin mapping: pins 0 and 1 trade places under swap
   for (genvar p = 0; p < NUM_BANKS; p++) begin : g_pin
      if (p < 2) begin : g_boot
         assign sel_o[p] = swap_i ? logical[1-p] : logical[p];
      end else begin : g_direct
         assign sel_o[p] = logical[p];
      end
   end
endmodule

// File: rtl/cs_bank_decoder.sv
module cs_bank_decoder
   import cs_dec_pkg::*;
#(
   parameter int unsigned NUM_BANKS = DEF_BANKS,
   parameter int unsigned ADDR_W    = DEF_ADDR_W,
   parameter int unsigned GRAN_LG2  = DEF_GRAN_LG2,
   parameter int unsigned REG_AW    = DEF_REG_AW,
   parameter int unsigned BASE_OFF  = DEF_BASE_OFF,
   parameter int unsigned STRIDE    = DEF_STRIDE
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 boot_swap_i,
   input  logic                 reg_valid_i,
   input  logic                 reg_write_i,
   input  logic [REG_AW-1:0]    reg_addr_i,
   input  logic [ADDR_W-1:0]    reg_wdata_i,
   output logic [ADDR_W-1:0]    reg_rdata_o,
   input  logic                 bus_valid_i,
   input  logic [ADDR_W-1:0]    bus_addr_i,
   output logic [NUM_BANKS-1:0] cs_n_o,
   output logic                 miss_o
);
   localparam int unsigned TAG_W = ADDR_W - GRAN_LG2;

   // Elaboration-time parameter checks
   if (NUM_BANKS < 2) begin : g_err_banks
      $error("cs_bank_decoder: at least two banks are needed");
   end
   if (TAG_W + 1 > GRAN_LG2) begin : g_err_fields
      $error("cs_bank_decoder: mask field would overlap the base field");
   end
   if (!is_pow2(STRIDE)) begin : g_err_stride
      $error("cs_bank_decoder: register stride must be a power of two");
   end
   if (BASE_OFF + NUM_BANKS * STRIDE > (1 << REG_AW)) begin : g_err_span
      $error("cs_bank_decoder: register window exceeds the offset range");
   end

   logic [NUM_BANKS-1:0][ADDR_W-1:0] bank_regs;
   logic                             swap;
   logic [NUM_BANKS-1:0]             hit;
   logic                             capture;
   logic [NUM_BANKS-1:0]             sel;
   logic                             miss;
   logic [NUM_BANKS-1:0]             cs_n_q;
   logic                             miss_q;

   cs_dec_regfile #(
      .NUM_BANKS (NUM_BANKS),
      .DATA_W    (ADDR_W),
      .REG_AW    (REG_AW),
      .BASE_OFF  (BASE_OFF),
      .STRIDE    (STRIDE)
   ) u_regfile (
      .clk         (clk),
      .rst_n       (rst_n),
      .boot_swap_i (boot_swap_i),
      .reg_valid_i (reg_valid_i),
      .reg_write_i (reg_write_i),
      .reg_addr_i  (reg_addr_i),
      .reg_wdata_i (reg_wdata_i),
      .reg_rdata_o (reg_rdata_o),
      .bank_regs_o (bank_regs),
      .swap_o      (swap)
   );

   cs_dec_match #(
      .NUM_BANKS (NUM_BANKS),
      .ADDR_W    (ADDR_W),
      .GRAN_LG2  (GRAN_LG2)
   ) u_match (
      .bank_regs_i (bank_regs),
      .addr_i      (bus_addr_i),
      .hit_o       (hit),
      .capture_o   (capture)
   );

   cs_dec_select #(
      .NUM_BANKS (NUM_BANKS)
   ) u_select (
      .hit_i     (hit),
      .capture_i (capture),
      .swap_i    (swap),
      .sel_o     (sel),
      .miss_o    (miss)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_n_q <= '1;
         miss_q <= 1'b0;
      end else if (bus_valid_i) begin
         cs_n_q <= ~sel;
         miss_q <= miss;
      end else begin
         cs_n_q <= '1;
         miss_q <= 1'b0;
      end
   end

   assign cs_n_o = cs_n_q;
   assign miss_o = miss_q;
endmodule

// File: rtl/cs_bank_decoder_chk.sv
module cs_bank_decoder_chk #(
   parameter int unsigned NUM_BANKS = 8,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned REG_AW    = 12,
   parameter int unsigned STRIDE    = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 reg_valid_i,
   input logic                 reg_write_i,
   input logic [REG_AW-1:0]    reg_addr_i,
   input logic [ADDR_W-1:0]    reg_rdata_o,
   input logic                 bus_valid_i,
   input logic [NUM_BANKS-1:0] cs_n_o,
   input logic                 miss_o
);
   localparam int unsigned STRIDE_LG2 = $clog2(STRIDE);

   // R4
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n_o));

   // R5
   miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miss_o |-> (&cs_n_o));

   // R8
   idle_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_valid_i) |-> ((&cs_n_o) && !miss_o));

   // R5
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_valid_i) |-> (miss_o == (&cs_n_o)));

   // R1
   rd_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid_i && !reg_write_i && (reg_addr_i[STRIDE_LG2-1:0] != '0))
         |-> (reg_rdata_o == '0));
endmodule

bind cs_bank_decoder cs_bank_decoder_chk #(
   .NUM_BANKS (NUM_BANKS),
   .ADDR_W    (ADDR_W),
   .REG_AW    (REG_AW),
   .STRIDE    (STRIDE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_valid_i (reg_valid_i),
   .reg_write_i (reg_write_i),
   .reg_addr_i  (reg_addr_i),
   .reg_rdata_o (reg_rdata_o),
   .bus_valid_i (bus_valid_i),
   .cs_n_o      (cs_n_o),
   .miss_o      (miss_o)
);

// File: tb/cs_bank_decoder_bench.sv
`timescale 1ns/1ps
module cs_bank_decoder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boot_swap_i = 1'b0;
   logic        reg_valid_i = 1'b0;
   logic        reg_write_i = 1'b0;
   logic [11:0] reg_addr_i = '0;
   logic [31:0] reg_wdata_i = '0;
   logic [31:0] reg_rdata_o;
   logic        bus_valid_i = 1'b0;
   logic [31:0] bus_addr_i = '0;
   logic [7:0]  cs_n_o;
   logic        miss_o;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   always #4 clk = ~clk;

   cs_bank_decoder u_cs_bank_decoder (
      .clk         (clk),
      .rst_n       (rst_n),
      .boot_swap_i (boot_swap_i),
      .reg_valid_i (reg_valid_i),
      .reg_write_i (reg_write_i),
      .reg_addr_i  (reg_addr_i),
      .reg_wdata_i (reg_wdata_i),
      .reg_rdata_o (reg_rdata_o),
      .bus_valid_i (bus_valid_i),
      .bus_addr_i  (bus_addr_i),
      .cs_n_o      (cs_n_o),
      .miss_o      (miss_o)
   );

   // {address, expected cs_n, expected miss} with the standard window set
   localparam logic [40:0] VEC [14] = '{
      {32'h0000_1234, 8'hFE, 1'b0},  // R3 bank 0
      {32'h000F_FFFF, 8'hFE, 1'b0},  // R3 bank 0 top edge
      {32'h0010_0000, 8'hFF, 1'b1},  // R5 just past bank 0
      {32'hFFFF_0000, 8'hFD, 1'b0},  // R10 bank 1 top window
      {32'hFFFD_FFFF, 8'hFF, 1'b1},  // R10 below top window
      {32'h0800_0000, 8'hFB, 1'b0},  // R3 bank 2
      {32'h0900_0010, 8'hFB, 1'b0},  // R4 banks 2 and 3 overlap
      {32'h0C00_0000, 8'hFF, 1'b1},  // R5
      {32'h2000_0000, 8'hEF, 1'b0},  // R3 bank 4 low edge
      {32'h2001_FFFF, 8'hEF, 1'b0},  // R3 bank 4 high edge
      {32'h2002_0000, 8'hFF, 1'b1},  // R5
      {32'h3000_0000, 8'hFF, 1'b1},  // R3 bank 5 disabled
      {32'h4FFF_FFFF, 8'hBF, 1'b0},  // R3 bank 6
      {32'h5000_0000, 8'hFF, 1'b1}   // R5
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply_reset(input logic strap);
      @(negedge clk);
      rst_n       = 1'b0;
      boot_swap_i = strap;
      bus_valid_i = 1'b0;
      reg_valid_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_valid_i = 1'b1;
      reg_write_i = 1'b1;
      reg_addr_i  = a;
      reg_wdata_i = d;
      @(negedge clk);
      reg_valid_i = 1'b0;
      reg_write_i = 1'b0;
   endtask

   task automatic reg_rd(input logic [11:0] a, input logic [31:0] exp,
                         input string req);
      @(negedge clk);
      reg_valid_i = 1'b1;
      reg_write_i = 1'b0;
      reg_addr_i  = a;
      #1;
      check(req, $sformatf("read 0x%03h", a), reg_rdata_o, exp);
      reg_valid_i = 1'b0;
   endtask

   task automatic access(input logic [31:0] a, input logic [7:0] exp_cs,
                         input logic exp_miss, input string req);
      @(negedge clk);
      bus_valid_i = 1'b1;
      bus_addr_i  = a;
      @(negedge clk);
      bus_valid_i = 1'b0;
      check(req, $sformatf("cs_n @%h", a), {24'h0, cs_n_o}, {24'h0, exp_cs});
      check(req, $sformatf("miss @%h", a), {31'h0, miss_o}, {31'h0, exp_miss});
   endtask

   initial begin
      // Reset with strap off
      apply_reset(1'b0);
      check("R8", "reset cs_n", {24'h0, cs_n_o}, 32'h0000_00FF);
      check("R8", "reset miss", {31'h0, miss_o}, 32'h0);
      reg_rd(12'h100, 32'h0000_0001, "R2");
      reg_rd(12'h110, 32'h0000_0000, "R2");
      reg_rd(12'h170, 32'h0000_0000, "R2");
      // R6: bank 1 register is zero after reset, so everything hits bank 0
      access(32'h4000_0000, 8'hFE, 1'b0, "R6");

      // Standard window set
      reg_wr(12'h100, 32'h0000_FFF1);
      reg_wr(12'h110, 32'hFFFF_FFFF);
      reg_wr(12'h120, 32'h0800_FC01);
      reg_wr(12'h130, 32'h0900_FF01);
      reg_wr(12'h140, 32'h2000_FFFF);
      reg_wr(12'h150, 32'h3000_FF00);
      reg_wr(12'h160, 32'h4000_F001);
      reg_wr(12'h170, 32'h0000_0000);
      reg_rd(12'h140, 32'h2000_FFFF, "R1");
      reg_rd(12'h150, 32'h3000_FF00, "R1");
      // R1: holes and out-of-window offsets
      reg_wr(12'h104, 32'hDEAD_BEEF);
      reg_rd(12'h104, 32'h0000_0000, "R1");
      reg_rd(12'h100, 32'h0000_FFF1, "R1");
      reg_wr(12'h180, 32'h1234_5671);
      reg_rd(12'h180, 32'h0000_0000, "R1");
      reg_rd(12'h0F0, 32'h0000_0000, "R1");

      // Table walk: R3, R4, R5, R10
      for (int i = 0; i < 14; i++) begin
         access(VEC[i][40:9], VEC[i][8:1], VEC[i][0],
                $sformatf("R3/R4/R5/R10 vec%0d", i));
      end

      // R8: idle after a strobe
      @(negedge clk);
      check("R8", "idle cs_n", {24'h0, cs_n_o}, 32'h0000_00FF);
      check("R8", "idle miss", {31'h0, miss_o}, 32'h0);

      // R4: with bank 2 disabled the overlap falls to bank 3
      reg_wr(12'h120, 32'h0800_FC00);
      access(32'h0900_0010, 8'hF7, 1'b0, "R4");

      // R9: write and access on the same edge, then on the next edge
      @(negedge clk);
      reg_valid_i = 1'b1; reg_write_i = 1'b1;
      reg_addr_i  = 12'h140; reg_wdata_i = 32'h2000_FFFE;
      bus_valid_i = 1'b1; bus_addr_i = 32'h2000_0000;
      @(negedge clk);
      reg_valid_i = 1'b0; reg_write_i = 1'b0;
      check("R9", "same-edge cs_n", {24'h0, cs_n_o}, 32'h0000_00EF);
      @(negedge clk);
      bus_valid_i = 1'b0;
      check("R9", "next-edge cs_n", {24'h0, cs_n_o}, 32'h0000_00FF);
      check("R9", "next-edge miss", {31'h0, miss_o}, 32'h1);

      // R6: zero in bank 0, then in bank 1
      reg_wr(12'h100, 32'h0000_0000);
      access(32'h4000_0000, 8'hFE, 1'b0, "R6");
      reg_wr(12'h100, 32'h0000_FFF1);
      reg_wr(12'h110, 32'h0000_0000);
      access(32'h4000_0000, 8'hFE, 1'b0, "R6");
      reg_wr(12'h110, 32'hFFFF_FFFF);
      access(32'h4000_0000, 8'hBF, 1'b0, "R6");

      // R7: strap set
      apply_reset(1'b1);
      reg_rd(12'h100, 32'h0000_0000, "R2");
      reg_rd(12'h110, 32'h0000_0001, "R2");
      access(32'h5000_0000, 8'hFD, 1'b0, "R7");
      reg_wr(12'h100, 32'h0000_FFF1);
      reg_wr(12'h110, 32'hFFFF_FFFF);
      reg_wr(12'h120, 32'h0800_FC01);
      access(32'h0000_1234, 8'hFD, 1'b0, "R7");
      access(32'hFFFF_0000, 8'hFE, 1'b0, "R7");
      access(32'h0800_0000, 8'hFB, 1'b0, "R7");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule